// File: doc/BRIEF.md
# Accelerometer Register Target on a Two-Wire Serial Bus

This block lets a bus master reach a small bank of 8-bit registers over a two-wire serial bus with open-drain data. The clock and data lines are sampled by the system clock, passed through a short synchroniser, and turned into edge and start/stop events. The target answers only at its own 7-bit address, 0x0F. It drives the data line through an output enable that pulls the line low.

A write is the device address with direction 0, then a register pointer byte, then any number of data bytes. A read sets the pointer the same way, then uses a repeated start and the device address with direction 1. The pointer steps by one after each data byte in both directions. Three configuration registers drive the functional logic. The acceleration inputs are copied into a snapshot that stays still for the whole of a read, so a burst read returns one coherent set of samples. A mode bit locks the configuration. A self-test register gives a one-shot response. A soft-reset command resets the configuration.

Top module: `acc_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 0x0F; bit 0 selects read (1) or write (0). Any other address is not acknowledged, and the target leaves the data line released until the next start condition.
- R2: In a write, the target acknowledges the address byte, the pointer byte and each data byte, and stores each data byte at the pointer.
- R3: In a read, data bytes are shifted out MSB first after the repeated start and the read address. A master acknowledge fetches the next byte. A master NACK ends the transfer and the data line stays released.
- R4: The 7-bit pointer steps by one after every data byte, for writes and for reads, and wraps from 0x7F to 0x00. Each byte loaded for a read gives a one-cycle rd_strobe_o pulse, with rd_addr_o holding that register's address.
- R5: Bit 7 of the pointer byte is ignored, so pointer byte 0x9C selects register 0x1C.
- R6: Register 0x0C reads 0x55. While bit 4 of register 0x1D is set, it reads 0xAA instead. Reading 0x0C clears that bit, so the next read returns 0x55.
- R7: Register 0x0F reads 0x05. Identity, sample and unmapped registers ignore writes. Unmapped registers read 0x00.
- R8: While bit 7 of register 0x1B is 1, writes to 0x1C and 0x1D are acknowledged but have no effect, and a write to 0x1B changes only bit 7.
- R9: A data byte with bit 7 set that is written to 0x1D is not acknowledged. It gives a one-cycle soft_reset_o pulse and returns the three configuration registers to their reset values. The rest of the transfer is ignored.
- R10: Registers 0x06..0x0B hold the X, Y and Z samples as low/high byte pairs. Each 12-bit sample is left-justified: the low byte holds D3..D0 in bits 7:4 and zeros below. The snapshot is held from the acknowledge of a read address until the next start or stop condition.
- R11: After reset, registers 0x1B, 0x1C and 0x1D hold 0x00, 0x3F and 0x4D, and the data line is released.
- R12: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| accel_x_i | input | ACC_BITS | Live X sample, two's complement |
| accel_y_i | input | ACC_BITS | Live Y sample, two's complement |
| accel_z_i | input | ACC_BITS | Live Z sample, two's complement |
| ctrl_main_o | output | 8 | Register 0x1B; bit 7 is the lock/operate bit |
| ctrl_orient_o | output | 8 | Register 0x1C |
| ctrl_feat_o | output | 8 | Register 0x1D; bit 4 arms self-test |
| soft_reset_o | output | 1 | One-cycle pulse on a soft-reset command |
| rd_strobe_o | output | 1 | One-cycle pulse for each register byte fetched for a read |
| rd_addr_o | output | 7 | Address of the last fetched register |

## Verification
Single write/readback pairs are taken from a table. They cover writable, read-only and unmapped registers, which tells storage apart from the read-only decode. Bursts are used in both directions, and a read starting at 0x7F checks the pointer wrap. The sample registers are read while the live inputs change in mid-burst, which shows whether the snapshot is held or follows the inputs. Directed transfers cover the lock bit, the self-test sequence, the soft-reset command, a pointer byte with bit 7 set, and a foreign address followed by further bus traffic.

// File: rtl/acc_i2c_pkg.sv
package acc_i2c_pkg;
    typedef enum logic [2:0] {
        BS_IDLE, BS_DEV, BS_REG, BS_WDAT, BS_ACK, BS_TX, BS_MACK, BS_IGNORE
    } bus_state_t;

    localparam logic [6:0] REG_ACC_BASE    = 7'h06;
    localparam logic [6:0] REG_SELFTEST    = 7'h0C;
    localparam logic [6:0] REG_ID          = 7'h0F;
    localparam logic [6:0] REG_CTRL_MAIN   = 7'h1B;
    localparam logic [6:0] REG_CTRL_ORIENT = 7'h1C;
    localparam logic [6:0] REG_CTRL_FEAT   = 7'h1D;

    localparam logic [7:0] ID_VALUE     = 8'h05;
    localparam logic [7:0] SELFTEST_OFF = 8'h55;
    localparam logic [7:0] SELFTEST_ON  = 8'hAA;
    localparam logic [7:0] RST_MAIN     = 8'h00;
    localparam logic [7:0] RST_ORIENT   = 8'h3F;
    localparam logic [7:0] RST_FEAT     = 8'h4D;
endpackage

// File: rtl/acc_line_sync.sv
module acc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sr, sda_sr;
    logic [STAGES:0]   scl_chain, sda_chain;
    logic              scl_prev, sda_prev, scl_s;

    assign scl_chain = {scl_sr, scl_i};
    assign sda_chain = {sda_sr, sda_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr   <= '1;
            sda_sr   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sr   <= scl_chain[STAGES-1:0];
            sda_sr   <= sda_chain[STAGES-1:0];
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s    = scl_sr[STAGES-1];
    assign sda_s    = sda_sr[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;
    assign start_ev = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_ev  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/acc_bus_fsm.sv
module acc_bus_fsm
    import acc_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [7:0] rd_data,
    input  logic       wr_reject,
    output logic       sda_oe,
    output logic [6:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       rd_en,
    output logic       freeze
);
    typedef struct packed {
        bus_state_t state;
        bus_state_t after;
        logic [3:0] cnt;
        logic [7:0] shreg;
        logic [6:0] ptr;
        logic       oe;
        logic       mack;
        logic       freeze;
    } fsm_t;

    fsm_t q, d;
    logic load;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        rd_en = 1'b0;
        load  = 1'b0;
        if (start_ev) begin
            d.state  = BS_DEV;
            d.cnt    = 4'd0;
            d.oe     = 1'b0;
            d.freeze = 1'b0;
        end else if (stop_ev) begin
            d.state  = BS_IDLE;
            d.oe     = 1'b0;
            d.freeze = 1'b0;
        end else begin
            case (q.state)
                BS_DEV, BS_REG, BS_WDAT: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        d.shreg = {q.shreg[6:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        if (q.state == BS_DEV) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                d.state  = BS_ACK;
                                d.oe     = 1'b1;
                                d.after  = q.shreg[0] ? BS_TX : BS_REG;
                                d.freeze = q.shreg[0];
                            end else begin
                                d.state = BS_IGNORE;
                            end
                        end else if (q.state == BS_REG) begin
                            d.ptr   = q.shreg[6:0];
                            d.state = BS_ACK;
                            d.oe    = 1'b1;
                            d.after = BS_WDAT;
                        end else begin
                            wr_en = 1'b1;
                            if (wr_reject) begin
                                d.state = BS_IGNORE;
                            end else begin
                                d.ptr   = q.ptr + 7'd1;
                                d.state = BS_ACK;
                                d.oe    = 1'b1;
                                d.after = BS_WDAT;
                            end
                        end
                    end
                end
                BS_ACK: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.state = q.after;
                        d.cnt   = 4'd0;
                        load    = (q.after == BS_TX);
                    end
                end
                BS_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe    = 1'b0;
                            d.state = BS_MACK;
                        end else begin
                            d.oe    = ~q.shreg[7];
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.cnt   = q.cnt + 4'd1;
                        end
                    end
                end
                BS_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) load = 1'b1;
                        else        d.state = BS_IGNORE;
                    end
                end
                default: ;
            endcase
        end
        if (load) begin
            rd_en   = 1'b1;
            d.shreg = {rd_data[6:0], 1'b0};
            d.oe    = ~rd_data[7];
            d.cnt   = 4'd1;
            d.ptr   = q.ptr + 7'd1;
            d.state = BS_TX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: BS_IDLE, after: BS_IDLE, cnt: 4'd0, shreg: 8'd0,
                   ptr: 7'd0, oe: 1'b0, mack: 1'b0, freeze: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign ptr     = q.ptr;
    assign wr_data = q.shreg;
    assign freeze  = q.freeze;
endmodule

// File: rtl/acc_reg_bank.sv
module acc_reg_bank
    import acc_i2c_pkg::*;
#(
    parameter int ACC_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [6:0]          addr,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    input  logic                rd_en,
    input  logic                freeze,
    input  logic [ACC_BITS-1:0] accel_x,
    input  logic [ACC_BITS-1:0] accel_y,
    input  logic [ACC_BITS-1:0] accel_z,
    output logic [7:0]          rd_data,
    output logic                wr_reject,
    output logic [7:0]          ctrl_main,
    output logic [7:0]          ctrl_orient,
    output logic [7:0]          ctrl_feat,
    output logic                soft_reset,
    output logic                rd_strobe,
    output logic [6:0]          rd_addr
);
    localparam int NUM_AXES = 3;
    localparam int PAD      = 16 - ACC_BITS;
    localparam logic [6:0] ACC_LAST = REG_ACC_BASE + 7'(2 * NUM_AXES - 1);

    typedef struct packed {
        logic [7:0]                         main;
        logic [7:0]                         orient;
        logic [7:0]                         feat;
        logic [NUM_AXES-1:0][ACC_BITS-1:0]  snap;
        logic                               srst;
        logic                               rstrobe;
        logic [6:0]                         raddr;
    } bank_t;

    bank_t q, d;
    logic [NUM_AXES-1:0][ACC_BITS-1:0] live;
    logic [2:0]  acc_off;
    logic [15:0] acc_word;

    assign live      = {accel_z, accel_y, accel_x};
    assign wr_reject = (addr == REG_CTRL_FEAT) && wr_data[7];
    assign acc_off   = 3'(addr - REG_ACC_BASE);
    assign acc_word  = {q.snap[acc_off[2:1]], {PAD{1'b0}}};

    always_comb begin
        rd_data = 8'h00;
        if (addr >= REG_ACC_BASE && addr <= ACC_LAST) begin
            rd_data = acc_off[0] ? acc_word[15:8] : acc_word[7:0];
        end else begin
            case (addr)
                REG_SELFTEST:    rd_data = q.feat[4] ? SELFTEST_ON : SELFTEST_OFF;
                REG_ID:          rd_data = ID_VALUE;
                REG_CTRL_MAIN:   rd_data = q.main;
                REG_CTRL_ORIENT: rd_data = q.orient;
                REG_CTRL_FEAT:   rd_data = q.feat;
                default:         rd_data = 8'h00;
            endcase
        end
    end

    always_comb begin
        d         = q;
        d.srst    = 1'b0;
        d.rstrobe = 1'b0;
        if (!freeze) d.snap = live;
        if (rd_en) begin
            d.rstrobe = 1'b1;
            d.raddr   = addr;
            if (addr == REG_SELFTEST) d.feat[4] = 1'b0;
        end
        if (wr_en) begin
            if (wr_reject) begin
                d.main   = RST_MAIN;
                d.orient = RST_ORIENT;
                d.feat   = RST_FEAT;
                d.srst   = 1'b1;
            end else if (!q.main[7]) begin
                case (addr)
                    REG_CTRL_MAIN:   d.main   = wr_data;
                    REG_CTRL_ORIENT: d.orient = wr_data;
                    REG_CTRL_FEAT:   d.feat   = wr_data;
                    default: ;
                endcase
            end else if (addr == REG_CTRL_MAIN) begin
                d.main[7] = wr_data[7];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{main: RST_MAIN, orient: RST_ORIENT, feat: RST_FEAT,
                   snap: '0, srst: 1'b0, rstrobe: 1'b0, raddr: 7'd0};
        end else begin
            q <= d;
        end
    end

    assign ctrl_main   = q.main;
    assign ctrl_orient = q.orient;
    assign ctrl_feat   = q.feat;
    assign soft_reset  = q.srst;
    assign rd_strobe   = q.rstrobe;
    assign rd_addr     = q.raddr;
endmodule

// File: rtl/acc_i2c_target.sv
module acc_i2c_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h0F,
    parameter int         SYNC_STAGES = 2,
    parameter int         ACC_BITS    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [ACC_BITS-1:0] accel_x_i,
    input  logic [ACC_BITS-1:0] accel_y_i,
    input  logic [ACC_BITS-1:0] accel_z_i,
    output logic [7:0]          ctrl_main_o,
    output logic [7:0]          ctrl_orient_o,
    output logic [7:0]          ctrl_feat_o,
    output logic                soft_reset_o,
    output logic                rd_strobe_o,
    output logic [6:0]          rd_addr_o
);
    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0] rd_data, wr_data;
    logic [6:0] ptr;
    logic       wr_reject, wr_en, rd_en, freeze;

    acc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    acc_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .rd_data(rd_data), .wr_reject(wr_reject), .sda_oe(sda_oe_o),
        .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .freeze(freeze)
    );

    acc_reg_bank #(.ACC_BITS(ACC_BITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .addr(ptr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .freeze(freeze),
        .accel_x(accel_x_i), .accel_y(accel_y_i), .accel_z(accel_z_i),
        .rd_data(rd_data), .wr_reject(wr_reject), .ctrl_main(ctrl_main_o),
        .ctrl_orient(ctrl_orient_o), .ctrl_feat(ctrl_feat_o),
        .soft_reset(soft_reset_o), .rd_strobe(rd_strobe_o),
        .rd_addr(rd_addr_o)
    );
endmodule

// File: rtl/acc_i2c_target_chk.sv
module acc_i2c_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [7:0] ctrl_main_o,
    input logic [7:0] ctrl_orient_o,
    input logic [7:0] ctrl_feat_o,
    input logic       soft_reset_o,
    input logic       rd_strobe_o
);
    p_sda_moves_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    p_locked_orient_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_main_o[7]) && !soft_reset_o) |-> $stable(ctrl_orient_o));

    p_locked_main_low_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_main_o[7]) && !soft_reset_o) |-> $stable(ctrl_main_o[6:0]));

    p_srst_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_o |=> !soft_reset_o);

    p_srst_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_reset_o) |-> (ctrl_main_o == 8'h00 && ctrl_orient_o == 8'h3F
                                  && ctrl_feat_o == 8'h4D));

    p_rd_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_o |=> !rd_strobe_o);
endmodule

bind acc_i2c_target acc_i2c_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .ctrl_main_o(ctrl_main_o), .ctrl_orient_o(ctrl_orient_o),
    .ctrl_feat_o(ctrl_feat_o), .soft_reset_o(soft_reset_o),
    .rd_strobe_o(rd_strobe_o)
);

// File: tb/acc_i2c_target_test.sv
module acc_i2c_target_test;
    localparam int Q = 5;
    localparam logic [7:0] DEV_W = 8'h1E;
    localparam logic [7:0] DEV_R = 8'h1F;
    localparam int NVEC = 6;
    // {pointer, data written, expected readback}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h1C1212, 24'h1D0303, 24'h1B1F1F, 24'h1B0000, 24'h20FF00, 24'h0F7705
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [11:0] ax = 12'd0, ay = 12'd0, az = 12'd0;
    logic [7:0] c_main, c_orient, c_feat;
    logic srst, rstb;
    logic [6:0] raddr;

    int errors = 0;
    int checks = 0;
    int strobe_cnt = 0;
    int srst_cnt = 0;
    int sda_bad = 0;
    logic [6:0] last_rd = 7'd0;
    logic prev_oe = 1'b0, prev_scl = 1'b1;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    acc_i2c_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .accel_x_i(ax), .accel_y_i(ay), .accel_z_i(az),
        .ctrl_main_o(c_main), .ctrl_orient_o(c_orient), .ctrl_feat_o(c_feat),
        .soft_reset_o(srst), .rd_strobe_o(rstb), .rd_addr_o(raddr)
    );

    always @(negedge clk) begin
        if (rstb) begin strobe_cnt++; last_rd = raddr; end
        if (srst) srst_cnt++;
        if (rst_n && sda_oe != prev_oe && scl && prev_scl) sda_bad++;
        prev_oe = sda_oe;
        prev_scl = scl;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(); scl = 1'b1; waitq();
        sda_m = 1'b0; waitq(); scl = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(); scl = 1'b1; waitq(); sda_m = 1'b1; waitq();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; waitq(); scl = 1'b1; waitq(); waitq(); scl = 1'b0; waitq();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; waitq(); scl = 1'b1; waitq(); b = sda_line; waitq();
        scl = 1'b0; waitq();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic last);
        logic b;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin rbit(b); v = {v[6:0], b}; end
        wbit(last);
    endtask

    task automatic write1(input logic [7:0] ra, input logic [7:0] v, output logic ok);
        logic a0, a1, a2;
        bus_start(); wbyte(DEV_W, a0); wbyte(ra, a1); wbyte(v, a2); bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic read_setup(input logic [7:0] ra, output logic ok);
        logic a0, a1, a2;
        bus_start(); wbyte(DEV_W, a0); wbyte(ra, a1);
        bus_start(); wbyte(DEV_R, a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic read1(input logic [7:0] ra, output logic [7:0] v);
        logic ok;
        read_setup(ra, ok);
        rbyte(v, 1'b1);
        bus_stop();
        check("R3 read address acknowledged", ok, 1);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ok, a;
        logic [7:0] v;
        int s0;
        logic [7:0] got [6];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11 reset state
        check("R11 sda released", sda_oe, 0);
        check("R11 main reset", c_main, 8'h00);
        check("R11 orient reset", c_orient, 8'h3F);
        check("R11 feat reset", c_feat, 8'h4D);
        read1(8'h1C, v);
        check("R11 orient via bus", v, 8'h3F);
        read1(8'h0F, v);
        check("R7 identity", v, 8'h05);

        // R2 R7 table of single write then readback
        for (int i = 0; i < NVEC; i++) begin
            write1(VEC[i][23:16], VEC[i][15:8], ok);
            check("R2 table write acknowledged", ok, 1);
            read1(VEC[i][23:16], v);
            check("R7 R2 table readback", v, VEC[i][7:0]);
        end

        // R2 R4 burst write
        bus_start(); wbyte(DEV_W, a); ok = a; wbyte(8'h1B, a); ok &= a;
        wbyte(8'h05, a); ok &= a; wbyte(8'h2A, a); ok &= a; wbyte(8'h0C, a); ok &= a;
        bus_stop();
        check("R2 burst acknowledged", ok, 1);
        check("R4 burst write main", c_main, 8'h05);
        check("R4 burst write orient", c_orient, 8'h2A);
        check("R4 burst write feat", c_feat, 8'h0C);

        // R3 R4 burst read
        s0 = strobe_cnt;
        read_setup(8'h1B, ok);
        rbyte(got[0], 1'b0); rbyte(got[1], 1'b0); rbyte(got[2], 1'b1);
        bus_stop();
        check("R3 burst byte0", got[0], 8'h05);
        check("R3 burst byte1", got[1], 8'h2A);
        check("R3 burst byte2", got[2], 8'h0C);
        check("R4 strobe count", strobe_cnt - s0, 3);
        check("R4 last strobe address", last_rd, 7'h1D);
        check("R3 released after NACK", sda_oe, 0);

        // R4 wrap
        read_setup(8'h7F, ok);
        rbyte(got[0], 1'b0); rbyte(got[1], 1'b1);
        bus_stop();
        check("R4 wrap to 0x00", last_rd, 7'h00);

        // R5 pointer msb ignored
        write1(8'h9C, 8'h21, ok);
        check("R5 pointer bit7 ignored", c_orient, 8'h21);

        // R6 self-test
        read1(8'h0C, v);
        check("R6 idle response", v, 8'h55);
        write1(8'h1D, 8'h10, ok);
        read1(8'h0C, v);
        check("R6 armed response", v, 8'hAA);
        check("R6 arm bit cleared by read", c_feat, 8'h00);
        read1(8'h0C, v);
        check("R6 back to idle", v, 8'h55);

        // R10 sample layout and freeze
        ax = 12'hABC; ay = 12'h123; az = 12'hF0F;
        read_setup(8'h06, ok);
        rbyte(got[0], 1'b0);
        ax = 12'h000; ay = 12'h000; az = 12'h000;
        for (int i = 1; i < 6; i++) rbyte(got[i], i == 5);
        bus_stop();
        check("R10 x low", got[0], 8'hC0);
        check("R10 x high", got[1], 8'hAB);
        check("R10 y low", got[2], 8'h30);
        check("R10 y high", got[3], 8'h12);
        check("R10 z low", got[4], 8'hF0);
        check("R10 z high", got[5], 8'hF0);
        read1(8'h07, v);
        check("R10 snapshot refreshed", v, 8'h00);

        // R8 lock
        write1(8'h1B, 8'h80, ok);
        write1(8'h1C, 8'h00, ok);
        check("R8 locked write acknowledged", ok, 1);
        check("R8 locked orient held", c_orient, 8'h21);
        write1(8'h1B, 8'h7F, ok);
        check("R8 only lock bit changes", c_main, 8'h00);
        write1(8'h1C, 8'h44, ok);
        check("R8 unlocked write", c_orient, 8'h44);

        // R9 soft reset
        write1(8'h1D, 8'h80, ok);
        check("R9 soft reset NACK", ok, 0);
        check("R9 pulse count", srst_cnt, 1);
        check("R9 orient default", c_orient, 8'h3F);
        check("R9 feat default", c_feat, 8'h4D);

        // R1 foreign address
        bus_start(); wbyte(8'h3C, a);
        check("R1 foreign address NACK", a, 0);
        wbyte(8'h1C, a);
        check("R1 ignored until start", a, 0);
        wbyte(8'h99, a);
        bus_stop();
        check("R1 foreign traffic no effect", c_orient, 8'h3F);

        check("R12 sda changes only with SCL low", sda_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule